// File: doc/BRIEF.md
# I2C Serial Clock Divider

This block turns a fast source clock into the serial clock of a two-wire bus master. One 32-bit divisor word sets the low and high phases of the serial clock separately, each in units of eight source clocks. The block runs while its enable input is high. While the enable is low it releases the clock line.

For the bit engine, the block marks the middle of every low phase, where the data line may change, and the middle of every high phase, where the data line is sampled. Each mark is a one-cycle strobe. The block reads the clock line back. If a slave holds the line low after the block has released it, high-phase counting waits until the line is seen high.

A divisor written while the clock runs does not change the period in progress. Both fields are captured together when the next low phase begins.

Top module: `scl_divgen`

## Requirements
- R1: While `enable` is low, `scl_out` is 1 and both strobes are 0 from the next clock edge on. This holds whatever `scl_in` and `div_word` do.
- R2: The low-phase count is `div_word[15:0]` = L. Every low phase keeps `scl_out` at 0 for exactly 8 × (L + 1) source clocks.
- R3: The high-phase count is `div_word[31:16]` = H. An unstretched high phase keeps `scl_out` at 1 for exactly 8 × (H + 1) source clocks.
- R4: With both fields 0, the serial clock is 8 cycles low and 8 cycles high, a period of 16 source clocks.
- R5: The two fields are independent. An odd total such as L = 2, H = 3 gives a high phase one unit (8 cycles) longer than the low phase.
- R6: `mid_low_stb` is high for exactly one cycle in each low phase, at cycle index 4 × (L + 1), counting the first low cycle as index 0.
- R7: `mid_high_stb` is high for exactly one cycle in each high phase, at counted-cycle index 4 × (H + 1). It is never high while `scl_in` is 0.
- R8: During a high phase, every cycle with `scl_in` at 0 freezes the phase counters and keeps `scl_out` at 1. If the slave releases after R paused cycles, the high phase lasts R + 8 × (H + 1) cycles.
- R9: `div_word` is sampled only on entry to a low phase. A change made during a low phase leaves that low phase and the following high phase at their old lengths. The next period uses the new values.
- R10: Dropping `enable` in mid-phase abandons the period. Raising it again starts a full, fresh low phase with the divisor present at that moment.
- R11: After a clock edge that sees `enable` high while the block is idle, `scl_out` is 0. That cycle is index 0 of the first low phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Run the serial clock while high |
| div_word | input | 32 | High-phase count in [31:16], low-phase count in [15:0] |
| scl_in | input | 1 | Serial clock line as read back from the bus |
| scl_out | output | 1 | 0 pulls the clock line low, 1 releases it |
| mid_low_stb | output | 1 | One-cycle mark at the middle of each low phase |
| mid_high_stb | output | 1 | One-cycle mark at the middle of each high phase |

## Verification
The bench builds the block with its default parameters: a prescale of 8 and 16-bit count fields. This keeps the real eight-cycle unit and the real field split of the divisor word, so both the bit positions and the phase arithmetic are exercised as used. Small field values (0 to 5) bring every phase down to tens of cycles. The bench can therefore count each phase and each strobe position exactly, for the fastest setting, for asymmetric and odd divisors, and for a mid-run divisor change. A stretch is released at a known cycle, which pins down the exact length of a paused high phase.

// File: rtl/scl_div_pkg.sv
// Shared types for the serial clock divider.
// Assumes: used by every module of the divider; no state lives here.
package scl_div_pkg;

    // Phase of the generated serial clock.
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LOW  = 2'd1,
        PH_HIGH = 2'd2
    } scl_phase_e;

endpackage

// File: rtl/scl_prescale.sv
// Fixed prescaler: counts source clocks within one divisor unit.
// Assumes: PRESCALE is a power of two, at least 2. The count is frozen
// while advance is low and is forced to zero by clear.
module scl_prescale #(
    parameter int PRESCALE = 8,
    localparam int PRE_W = $clog2(PRESCALE)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             advance,
    output logic [PRE_W-1:0] pre_q,
    output logic             wrap
);

    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRESCALE - 1);

    // Last source clock of a unit on an advancing cycle.
    assign wrap = advance && (pre_q == PRE_LAST);

    // Step the in-unit position, wrapping after PRESCALE cycles.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            pre_q <= '0;
        end else if (advance) begin
            pre_q <= wrap ? '0 : pre_q + 1'b1;
        end
    end

endmodule

// File: rtl/scl_unit_cnt.sv
// Unit counter: counts divisor units within one phase, up to a limit.
// Assumes: limit is stable while the count is nonzero. It is switched
// only at phase boundaries, when the count returns to zero.
module scl_unit_cnt #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             step,
    input  logic [CNT_W-1:0] limit,
    output logic [CNT_W-1:0] unit_q,
    output logic             last
);

    // The current unit is the final one of the phase.
    assign last = (unit_q == limit);

    // Count units, returning to zero after the final one.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            unit_q <= '0;
        end else if (step) begin
            unit_q <= last ? '0 : unit_q + 1'b1;
        end
    end

    // The count never passes the phase limit.
    assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
        unit_q <= limit);

endmodule

// File: rtl/scl_phase_ctl.sv
// Phase sequencer: idle -> low -> high -> low ... while enabled.
// Captures both divisor fields together on every entry to a low phase.
// Assumes: phase_done is a one-cycle pulse on the last cycle of a phase.
module scl_phase_ctl
    import scl_div_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               enable,
    input  logic [2*CNT_W-1:0] div_word,
    input  logic               phase_done,
    output scl_phase_e         phase_q,
    output logic [CNT_W-1:0]   lo_lim,
    output logic [CNT_W-1:0]   hi_lim
);

    scl_phase_e phase_d;
    logic       enter_low;

    // Next phase from the enable and the end of the current phase.
    always_comb begin
        phase_d = phase_q;
        if (!enable) begin
            phase_d = PH_IDLE;
        end else begin
            case (phase_q)
                PH_IDLE: phase_d = PH_LOW;
                PH_LOW:  if (phase_done) phase_d = PH_HIGH;
                PH_HIGH: if (phase_done) phase_d = PH_LOW;
                default: phase_d = PH_IDLE;
            endcase
        end
    end

    assign enter_low = (phase_d == PH_LOW) && (phase_q != PH_LOW);

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
        end else begin
            phase_q <= phase_d;
        end
    end

    // Divisor capture at the start of each low phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_lim <= '0;
            hi_lim <= '0;
        end else if (enter_low) begin
            lo_lim <= div_word[CNT_W-1:0];
            hi_lim <= div_word[2*CNT_W-1:CNT_W];
        end
    end

    // Within a low phase, and on the way out of it, the captured counts hold.
    assert_lim_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_LOW) |=> ($stable(lo_lim) && $stable(hi_lim)));

endmodule

// File: rtl/scl_mid_detect.sv
// Midpoint detector: flags the cycle half-way through a phase.
// The phase position is unit * PRESCALE + in-unit count. The midpoint is
// (limit + 1) * PRESCALE / 2.
// Assumes: PRESCALE is a power of two, so the position is a concatenation.
module scl_mid_detect #(
    parameter int CNT_W = 16,
    parameter int PRE_W = 3,
    localparam int POS_W = CNT_W + PRE_W
) (
    input  logic [CNT_W-1:0] unit_q,
    input  logic [PRE_W-1:0] pre_q,
    input  logic [CNT_W-1:0] limit,
    output logic             at_mid
);

    logic [CNT_W:0]   lim_p1;
    logic [POS_W-1:0] position;
    logic [POS_W-1:0] target;

    // Compare the running position with the half-phase point.
    always_comb begin
        lim_p1   = {1'b0, limit} + 1'b1;
        position = {unit_q, pre_q};
        target   = POS_W'(lim_p1) << (PRE_W - 1);
        at_mid   = (position == target);
    end

endmodule

// File: rtl/scl_divgen.sv
// Serial clock divider top.
// Builds each phase from a prescaler (source clocks per unit) and a unit
// counter (units per phase). Produces mid-phase strobes and pauses
// high-phase counting while the read-back line is held low.
// Assumes: scl_in is already synchronous to clk. The phase enum decode
// driving scl_out is glitch-safe for an open-drain pad enable.
module scl_divgen
    import scl_div_pkg::*;
#(
    parameter int PRESCALE = 8,
    parameter int CNT_W    = 16,
    localparam int PRE_W   = $clog2(PRESCALE)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               enable,
    input  logic [2*CNT_W-1:0] div_word,
    input  logic               scl_in,
    output logic               scl_out,
    output logic               mid_low_stb,
    output logic               mid_high_stb
);

    scl_phase_e       phase_q;
    logic [CNT_W-1:0] lo_lim;
    logic [CNT_W-1:0] hi_lim;
    logic [CNT_W-1:0] limit;
    logic [PRE_W-1:0] pre_q;
    logic [CNT_W-1:0] unit_q;
    logic             pre_wrap;
    logic             unit_last;
    logic             clear;
    logic             advance;
    logic             phase_done;
    logic             at_mid;

    // Counter control: hold at zero when idle, pause on a stretched high.
    always_comb begin
        clear      = !enable || (phase_q == PH_IDLE);
        advance    = (phase_q == PH_LOW) || ((phase_q == PH_HIGH) && scl_in);
        limit      = (phase_q == PH_HIGH) ? hi_lim : lo_lim;
        phase_done = pre_wrap && unit_last;
    end

    scl_phase_ctl #(
        .CNT_W      (CNT_W)
    ) u_phase (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (enable),
        .div_word   (div_word),
        .phase_done (phase_done),
        .phase_q    (phase_q),
        .lo_lim     (lo_lim),
        .hi_lim     (hi_lim)
    );

    scl_prescale #(
        .PRESCALE (PRESCALE)
    ) u_pre (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (clear),
        .advance  (advance),
        .pre_q    (pre_q),
        .wrap     (pre_wrap)
    );

    scl_unit_cnt #(
        .CNT_W  (CNT_W)
    ) u_unit (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (clear),
        .step   (pre_wrap),
        .limit  (limit),
        .unit_q (unit_q),
        .last   (unit_last)
    );

    scl_mid_detect #(
        .CNT_W  (CNT_W),
        .PRE_W  (PRE_W)
    ) u_mid (
        .unit_q (unit_q),
        .pre_q  (pre_q),
        .limit  (limit),
        .at_mid (at_mid)
    );

    // Line drive and strobes from the phase and the midpoint match.
    always_comb begin
        scl_out      = (phase_q != PH_LOW);
        mid_low_stb  = (phase_q == PH_LOW) && at_mid;
        mid_high_stb = (phase_q == PH_HIGH) && scl_in && at_mid;
    end

    // Disabled: line released and no strobes from the next edge.
    assert_idle_released_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (scl_out && !mid_low_stb && !mid_high_stb));

    // Low-phase mark lasts one cycle.
    assert_low_stb_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mid_low_stb && enable) |=> !mid_low_stb);

    // High-phase mark lasts one cycle.
    assert_high_stb_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mid_high_stb && enable) |=> !mid_high_stb);

    // A stretched high phase freezes the counters and keeps the line released.
    assert_stretch_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((phase_q == PH_HIGH) && !scl_in && enable) |=>
            ($stable(pre_q) && $stable(unit_q) && scl_out));

    // First enabled edge from idle pulls the line low.
    assert_start_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ((phase_q == PH_IDLE) && enable) |=> !scl_out);

endmodule

// File: tb/scl_divgen_bench.sv
`timescale 1ns/1ps
module scl_divgen_bench;

    localparam int CLK_HALF = 4;   // 125 MHz
    localparam int UNIT     = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic        slave_low = 1'b0;
    logic [31:0] div_word = '0;
    logic        scl_in;
    logic        scl_out;
    logic        mid_low_stb;
    logic        mid_high_stb;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #CLK_HALF clk = ~clk;

    // Wired-AND bus line: a slave can hold it low.
    assign scl_in = scl_out & ~slave_low;

    scl_divgen u_scl_divgen (
        .clk          (clk),
        .rst_n        (rst_n),
        .enable       (enable),
        .div_word     (div_word),
        .scl_in       (scl_in),
        .scl_out      (scl_out),
        .mid_low_stb  (mid_low_stb),
        .mid_high_stb (mid_high_stb)
    );

    task automatic check_eq(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Measure a run of scl_out == lvl, starting at the current negedge sample.
    task automatic measure(input logic lvl, input int release_at,
                           output int len, output int stb_idx,
                           output int stb_cnt, output int wrong);
        len = 0; stb_idx = -1; stb_cnt = 0; wrong = 0;
        while (scl_out === lvl && len < 100000) begin
            if (lvl == 1'b0) begin
                if (mid_low_stb)  begin stb_idx = len; stb_cnt++; end
                if (mid_high_stb) wrong++;
            end else begin
                if (mid_high_stb) begin stb_idx = len; stb_cnt++; end
                if (mid_low_stb)  wrong++;
            end
            if (len == release_at) slave_low = 1'b0;
            len++;
            @(negedge clk);
        end
    endtask

    // Fresh start from idle with the given counts (R11 check included).
    task automatic start_clock(input int lo, input int hi);
        enable = 1'b0;
        slave_low = 1'b0;
        repeat (3) @(negedge clk);
        div_word = {hi[15:0], lo[15:0]};
        enable = 1'b1;
        @(negedge clk);
        check_eq("R11 line low one edge after enable", int'(scl_out), 0);
    endtask

    task automatic test_reset();
        @(negedge clk);
        check_eq("R1 released in reset", int'(scl_out), 1);
        check_eq("R1 no strobes in reset", int'(mid_low_stb | mid_high_stb), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check_eq("R1 released while disabled", int'(scl_out), 1);
    endtask

    task automatic test_fastest();
        int len, idx, cnt, wr, total;
        start_clock(0, 0);
        measure(1'b0, -1, len, idx, cnt, wr);
        total = len;
        check_eq("R4 low length at zero divisor", len, 8);
        check_eq("R6 low mark position", idx, 4);
        measure(1'b1, -1, len, idx, cnt, wr);
        total += len;
        check_eq("R4 high length at zero divisor", len, 8);
        check_eq("R7 high mark position", idx, 4);
        check_eq("R4 period 16", total, 16);
    endtask

    task automatic test_asym(input int lo, input int hi);
        int len, idx, cnt, wr;
        start_clock(lo, hi);
        for (int p = 0; p < 2; p++) begin
            measure(1'b0, -1, len, idx, cnt, wr);
            check_eq("R2 low length", len, UNIT * (lo + 1));
            check_eq("R6 low mark position", idx, 4 * (lo + 1));
            check_eq("R6 one low mark", cnt, 1);
            measure(1'b1, -1, len, idx, cnt, wr);
            check_eq("R3 high length", len, UNIT * (hi + 1));
            check_eq("R7 high mark position", idx, 4 * (hi + 1));
            check_eq("R7 one high mark, no low mark", cnt * 10 + wr, 10);
        end
    endtask

    task automatic test_odd();
        int lo_len, hi_len, idx, cnt, wr;
        start_clock(2, 3);
        measure(1'b0, -1, lo_len, idx, cnt, wr);
        measure(1'b1, -1, hi_len, idx, cnt, wr);
        check_eq("R5 high one unit longer than low", hi_len - lo_len, UNIT);
    endtask

    task automatic test_stretch();
        int len, idx, cnt, wr;
        start_clock(1, 1);
        slave_low = 1'b1;
        measure(1'b0, -1, len, idx, cnt, wr);
        check_eq("R2 low length before stretch", len, 16);
        measure(1'b1, 9, len, idx, cnt, wr);
        check_eq("R8 stretched high length", len, 9 + 16);
        check_eq("R8 high mark after release", idx, 9 + 8);
        check_eq("R7 single high mark with stretch", cnt, 1);
        measure(1'b0, -1, len, idx, cnt, wr);
        check_eq("R8 low after stretch unchanged", len, 16);
    endtask

    task automatic test_update();
        int len, idx, cnt, wr;
        start_clock(1, 1);
        div_word = {16'd2, 16'd3};
        measure(1'b0, -1, len, idx, cnt, wr);
        check_eq("R9 current low keeps old count", len, 16);
        measure(1'b1, -1, len, idx, cnt, wr);
        check_eq("R9 following high keeps old count", len, 16);
        measure(1'b0, -1, len, idx, cnt, wr);
        check_eq("R9 next low uses new count", len, 32);
        measure(1'b1, -1, len, idx, cnt, wr);
        check_eq("R9 next high uses new count", len, 24);
    endtask

    task automatic test_disable();
        int len, idx, cnt, wr, bad;
        start_clock(2, 2);
        measure(1'b0, -1, len, idx, cnt, wr);
        repeat (5) @(negedge clk);
        enable = 1'b0;
        @(negedge clk);
        check_eq("R10 released after disable", int'(scl_out), 1);
        bad = 0;
        slave_low = 1'b1;
        for (int i = 0; i < 30; i++) begin
            div_word = {16'(i), 16'(i + 1)};
            @(negedge clk);
            if (scl_out !== 1'b1 || mid_low_stb || mid_high_stb) bad++;
        end
        check_eq("R1 idle ignores line and divisor", bad, 0);
        slave_low = 1'b0;
        div_word = {16'd0, 16'd1};
        enable = 1'b1;
        @(negedge clk);
        check_eq("R10 restart pulls line low", int'(scl_out), 0);
        measure(1'b0, -1, len, idx, cnt, wr);
        check_eq("R10 fresh low phase length", len, 16);
        measure(1'b1, -1, len, idx, cnt, wr);
        check_eq("R10 fresh high phase length", len, 8);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        test_reset();
        test_fastest();
        test_asym(2, 3);
        test_asym(5, 1);
        test_odd();
        test_stretch();
        test_update();
        test_disable();
        finish_run();
    end

    initial begin
        #(2 * CLK_HALF * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog (all requirements): actual hung expected finished");
            finish_run();
        end
    end

endmodule